// File: doc/BRIEF.md
# Suspended-Sector Read Data Guard

This block sits in the read-array path of a serial flash device. It owns the auto-incrementing read address counter and, on every cycle, compares the sector that the counter points at with two suspend records: one naming the sector whose program operation is on hold, one naming the sector whose erase operation is on hold. Each record has its own valid flag. A byte read from a suspended sector is not defined, so the guard replaces it with a fixed filler byte. A byte read from any other sector passes through unchanged from the array.

A read burst starts with a load of the start address. Each step strobe then advances the counter by one. The counter wraps from the last array address to zero. The suspend check is made afresh for every address, so a single burst can move from real data into filler and back again as it crosses sector boundaries, with no new command. The mask decision is registered in the same stage as the array byte, so the byte handed to the serialiser and its filler flag always describe the same address.

Top module: `sect_read_guard`

## Requirements
- R1: The sector index of an address is its bits from SECT_LOG2 upward. The default SECT_LOG2 is 16, giving 64 KB sectors. Two addresses share a sector exactly when they agree in those bits.
- R2: When prog_sus_valid is 1 and the presented address lies in sector prog_sus_sect, the registered out_byte is FILL (default 8'hFF) and out_fill is 1.
- R3: When erase_sus_valid is 1 and the presented address lies in sector erase_sus_sect, the registered out_byte is FILL and out_fill is 1. This holds independently of the program record, and also when both records match.
- R4: A suspend record whose valid flag is 0 has no effect. When neither valid record matches, out_byte equals the array byte for that address and out_fill is 0.
- R5: During one continuous burst, the mask is decided anew for every address. Output switches between array data and filler at each sector boundary, in both directions, with no reload.
- R6: Each cycle with rd_step=1 and rd_load=0 advances rd_addr by one. rd_addr holds when neither strobe is set. From the highest address it wraps to 0, and the suspend check applies to the wrapped address.
- R7: rd_load=1 places rd_start_addr on rd_addr at the next clock edge. It takes priority over rd_step in the same cycle.
- R8: out_byte and out_fill are registered. The values present after a clock edge describe the rd_addr, arr_byte and suspend inputs seen just before that edge.
- R9: A synchronous active-low reset clears rd_addr, out_byte and out_fill to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_load | input | 1 | Load start address for a new burst |
| rd_start_addr | input | ADDR_W | Start address of the burst |
| rd_step | input | 1 | Address-increment strobe |
| rd_addr | output | ADDR_W | Current read address sent to the array |
| arr_byte | input | DATA_W | Array byte for rd_addr |
| prog_sus_valid | input | 1 | Program-suspend record is active |
| prog_sus_sect | input | ADDR_W-SECT_LOG2 | Sector holding the suspended program |
| erase_sus_valid | input | 1 | Erase-suspend record is active |
| erase_sus_sect | input | ADDR_W-SECT_LOG2 | Sector holding the suspended erase |
| out_byte | output | DATA_W | Guarded byte for the serialiser |
| out_fill | output | 1 | out_byte is filler, not array data |

## Verification
Two functions can fall in the same cycle: the counter's wrap from the top address to zero, and the suspend check deciding that the wrapped address is masked. The bench provokes this by placing a valid suspend record on sector 0 and starting a burst a few bytes below the top of the array. It then expects filler on exactly the byte after the wrap. The same sweep covers every sector as the program target and every sector as the erase target, with each burst running a full lap. Every presented byte is judged against an arithmetic array pattern and a sector index computed by division.

// File: rtl/sgd_pkg.sv
// Package: shared types for the suspended-sector read guard.
// Assumes: at most two suspend records (program and erase).
package sgd_pkg;

    // Which suspend record(s) claim the presented address.
    typedef enum logic [1:0] {
        SRC_NONE  = 2'b00,
        SRC_PROG  = 2'b01,
        SRC_ERASE = 2'b10,
        SRC_BOTH  = 2'b11
    } hit_src_t;

    // Fold the two per-record hit bits into a source code.
    function automatic hit_src_t fold_hits(input logic prog_hit, input logic erase_hit);
        return hit_src_t'({erase_hit, prog_hit});
    endfunction

endpackage

// File: rtl/sgd_addr_ctr.sv
// Module: read address counter for one burst.
// Loads a start address, steps by one per strobe, wraps at the top of the
// array. Assumes: load has priority over step; synchronous active-low reset.
module sgd_addr_ctr #(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              step,
    output logic [ADDR_W-1:0] addr
);

    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

    // Purpose: hold, load or advance the current address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr <= '0;
        else if (load)
            addr <= load_addr;
        else if (step)
            addr <= addr + ADDR_ONE;
    end

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (addr == $past(load_addr))); // R7

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(addr)); // R6

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && (addr == '1)) |=> (addr == '0)); // R6

endmodule

// File: rtl/sgd_sect_match.sv
// Module: compare the sector of an address with one suspend record.
// Assumes: sector index is the address bits from SECT_LOG2 upward; a record
// with its valid flag low never matches.
module sgd_sect_match #(
    parameter int ADDR_W    = 24,
    parameter int SECT_LOG2 = 16
) (
    input  logic                        rst_n,
    input  logic                        clk,
    input  logic [ADDR_W-1:0]           addr,
    input  logic                        sus_valid,
    input  logic [ADDR_W-SECT_LOG2-1:0] sus_sect,
    output logic                        hit
);

    localparam int SECT_W = ADDR_W - SECT_LOG2;

    logic [SECT_W-1:0] cur_sect;

    // Purpose: extract the sector index and compare with the record.
    always_comb begin
        cur_sect = addr[ADDR_W-1:SECT_LOG2];
        hit      = sus_valid && (cur_sect == sus_sect);
    end

    AST_INVALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !sus_valid |-> !hit); // R4

endmodule

// File: rtl/sgd_out_stage.sv
// Module: output register that keeps the byte and its mask aligned.
// Assumes: array byte and hit source both refer to the same address in the
// same cycle; FILL stands in for undefined data.
module sgd_out_stage
    import sgd_pkg::*;
#(
    parameter int               DATA_W = 8,
    parameter logic [DATA_W-1:0] FILL  = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] arr_data,
    input  hit_src_t          src,
    output logic [DATA_W-1:0] data_q,
    output logic              fill_q
);

    logic masked;

    // Purpose: any claiming record masks the byte.
    always_comb masked = (src != SRC_NONE);

    // Purpose: register the guarded byte together with its filler flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            fill_q <= 1'b0;
        end else begin
            data_q <= masked ? FILL : arr_data;
            fill_q <= masked;
        end
    end

    AST_MASK_GIVES_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (src != SRC_NONE) |=> (fill_q && (data_q == FILL))); // R2

    AST_CLEAR_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_NONE) |=> (!fill_q && (data_q == $past(arr_data)))); // R4

endmodule

// File: rtl/sect_read_guard.sv
// Module: top of the suspended-sector read data guard.
// Steps the read address, checks each address against the program and erase
// suspend records, and replaces bytes of suspended sectors with FILL.
// Assumes: arr_byte reflects rd_addr in the same cycle; suspend records are
// live inputs and are evaluated on every address.
module sect_read_guard
    import sgd_pkg::*;
#(
    parameter int                ADDR_W    = 24,
    parameter int                SECT_LOG2 = 16,
    parameter int                DATA_W    = 8,
    parameter logic [DATA_W-1:0] FILL      = 8'hFF
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rd_load,
    input  logic [ADDR_W-1:0]           rd_start_addr,
    input  logic                        rd_step,
    output logic [ADDR_W-1:0]           rd_addr,
    input  logic [DATA_W-1:0]           arr_byte,
    input  logic                        prog_sus_valid,
    input  logic [ADDR_W-SECT_LOG2-1:0] prog_sus_sect,
    input  logic                        erase_sus_valid,
    input  logic [ADDR_W-SECT_LOG2-1:0] erase_sus_sect,
    output logic [DATA_W-1:0]           out_byte,
    output logic                        out_fill
);

    localparam int SECT_W = ADDR_W - SECT_LOG2;
    localparam int N_REC  = 2;

    logic [N_REC-1:0]  rec_valid;
    logic [SECT_W-1:0] rec_sect [N_REC];
    logic [N_REC-1:0]  rec_hit;
    hit_src_t          src;

    // Purpose: gather the two suspend records into indexed form.
    always_comb begin
        rec_valid   = {erase_sus_valid, prog_sus_valid};
        rec_sect[0] = prog_sus_sect;
        rec_sect[1] = erase_sus_sect;
    end

    sgd_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (rd_load),
        .load_addr (rd_start_addr),
        .step      (rd_step),
        .addr      (rd_addr)
    );

    for (genvar g = 0; g < N_REC; g++) begin : g_rec
        sgd_sect_match #(.ADDR_W(ADDR_W), .SECT_LOG2(SECT_LOG2)) u_match (
            .rst_n     (rst_n),
            .clk       (clk),
            .addr      (rd_addr),
            .sus_valid (rec_valid[g]),
            .sus_sect  (rec_sect[g]),
            .hit       (rec_hit[g])
        );
    end

    // Purpose: encode which records claim the current address.
    always_comb src = fold_hits(rec_hit[0], rec_hit[1]);

    sgd_out_stage #(.DATA_W(DATA_W), .FILL(FILL)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .arr_data (arr_byte),
        .src      (src),
        .data_q   (out_byte),
        .fill_q   (out_fill)
    );

    AST_ERASE_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_sus_valid && (rd_addr[ADDR_W-1:SECT_LOG2] == erase_sus_sect))
        |=> (out_fill && (out_byte == FILL))); // R3

    AST_FLAG_MEANS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        out_fill |-> (out_byte == FILL)); // R8

endmodule

// File: tb/tb_sect_read_guard.sv
module tb_sect_read_guard;

    localparam int AW = 10;
    localparam int SL = 6;
    localparam int SW = AW - SL;
    localparam int NSECT = 1 << SW;
    localparam int SECT_BYTES = 1 << SL;
    localparam int TOP = (1 << AW);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_load = 1'b0;
    logic [AW-1:0] rd_start_addr = '0;
    logic          rd_step = 1'b0;
    logic [AW-1:0] rd_addr;
    logic [7:0]    arr_byte;
    logic          prog_sus_valid = 1'b0;
    logic [SW-1:0] prog_sus_sect = '0;
    logic          erase_sus_valid = 1'b0;
    logic [SW-1:0] erase_sus_sect = '0;
    logic [7:0]    out_byte;
    logic          out_fill;

    int checks = 0;
    int failures = 0;
    int model = 0;
    bit done = 0;

    always #10 clk = ~clk;

    // Array model: arithmetic pattern of the address.
    function automatic logic [7:0] pattern(input int a);
        return 8'((a * 37 + (a >> 8) * 11 + 3) & 255);
    endfunction

    assign arr_byte = pattern(int'(rd_addr));

    sect_read_guard #(.ADDR_W(AW), .SECT_LOG2(SL), .DATA_W(8), .FILL(8'hFF)) dut (
        .clk(clk), .rst_n(rst_n), .rd_load(rd_load), .rd_start_addr(rd_start_addr),
        .rd_step(rd_step), .rd_addr(rd_addr), .arr_byte(arr_byte),
        .prog_sus_valid(prog_sus_valid), .prog_sus_sect(prog_sus_sect),
        .erase_sus_valid(erase_sus_valid), .erase_sus_sect(erase_sus_sect),
        .out_byte(out_byte), .out_fill(out_fill)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected fill decision: sector index computed by division.
    function automatic bit exp_fill(input int a);
        int s;
        s = a / SECT_BYTES;
        return (prog_sus_valid && s == int'(prog_sus_sect)) ||
               (erase_sus_valid && s == int'(erase_sus_sect));
    endfunction

    // One cycle from a negedge to the next; judge output and address.
    task automatic step_one(input bit stp, input string req);
        int a;
        bit f;
        a = model;
        f = exp_fill(a);
        rd_step = stp;
        @(negedge clk);
        check(out_fill == f, req, int'(out_fill), int'(f));
        check(out_byte == (f ? 8'hFF : pattern(a)), req, int'(out_byte),
              int'(f ? 8'hFF : pattern(a)));
        if (stp) model = (model + 1) % TOP;
        check(int'(rd_addr) == model, "R6", int'(rd_addr), model);
    endtask

    task automatic load_at(input int a, input bit with_step);
        rd_load = 1'b1;
        rd_step = with_step;
        rd_start_addr = AW'(a);
        @(negedge clk);
        rd_load = 1'b0;
        rd_step = 1'b0;
        model = a;
        check(int'(rd_addr) == a, "R7", int'(rd_addr), a);
    endtask

    task automatic burst(input int start, input int n, input string req);
        load_at(start, 1'b0);
        for (int i = 0; i < n; i++) step_one(1'b1, req);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check(rd_addr == '0, "R9", int'(rd_addr), 0);
        check(out_byte == 8'h00, "R9", int'(out_byte), 0);
        check(out_fill == 1'b0, "R9", int'(out_fill), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: records present but invalid, matching sectors ignored
        prog_sus_sect = SW'(3); erase_sus_sect = SW'(5);
        burst(0, TOP + 4, "R4");

        // R2 / R5: program record on each sector, erase record invalid
        prog_sus_valid = 1'b1;
        for (int s = 0; s < NSECT; s++) begin
            prog_sus_sect = SW'(s);
            erase_sus_sect = SW'((s + 7) % NSECT);
            burst((s * SECT_BYTES + TOP - 3) % TOP, TOP, "R2_R5");
        end
        prog_sus_valid = 1'b0;

        // R3 / R1: erase record on each sector, program record invalid
        erase_sus_valid = 1'b1;
        for (int s = 0; s < NSECT; s++) begin
            erase_sus_sect = SW'(s);
            prog_sus_sect = SW'(s);
            burst((s * SECT_BYTES + 5) % TOP, TOP, "R3_R1");
        end

        // R3 / R5: both records, adjacent and identical sectors
        prog_sus_valid = 1'b1;
        for (int s = 0; s < NSECT; s++) begin
            prog_sus_sect = SW'(s);
            erase_sus_sect = SW'((s + (s % 2)) % NSECT);
            burst((s * SECT_BYTES) % TOP, 3 * SECT_BYTES, "R3_R5");
        end

        // R6: wrap from top to 0 lands in suspended sector 0
        prog_sus_valid = 1'b1; prog_sus_sect = SW'(0);
        erase_sus_valid = 1'b0;
        burst(TOP - 4, 10, "R6");

        // R6 / R8: hold with no step, output stays on same address
        for (int i = 0; i < 4; i++) step_one(1'b0, "R8");

        // R7: load beats step in the same cycle
        load_at(200, 1'b1);
        step_one(1'b1, "R8");
        load_at(TOP - 1, 1'b1);

        // R8: suspend record changed live, seen on next byte
        prog_sus_sect = SW'((TOP - 1) / SECT_BYTES);
        step_one(1'b1, "R8");
        prog_sus_valid = 1'b0;
        step_one(1'b1, "R8");

        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule